// File: doc/BRIEF.md
# NOR Flash Byte Program Sequencer

This block writes one byte into an 8-bit NOR flash on behalf of a requester. A request carries an address and a byte. The sequencer first reads the target location. If the stored byte already equals the new one, it finishes at once and sends nothing to the device.

When the byte differs, the sequencer notes whether the new value would need any bit raised from 0 to 1. It does not stop for this. It issues the three unlock and program command writes, then the data write. After that it reads status from the target until two consecutive reads agree or a read limit is reached. It keeps the last four status samples, so an older sample is still available to classify a failure.

The requester sees a single-cycle acknowledge with a two-bit result. The flash side is a synchronous bus master. Each transfer holds `fl_valid` until the device answers with `fl_ready`.

Top module: `nor_byte_prog`

## Requirements
- R1: After a request, the first bus transfer is a read of the target address. If the returned byte equals the requested byte, the operation ends with result code 0 (ok) and no write transfers occur.
- R2: If the old byte has any bit at 0 where the requested byte has a 1, and the program completes with the final read equal to the requested byte, the result code is 1 (zero-to-one warning). The program sequence is still issued in full.
- R3: A program consists of exactly four writes in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, and then the requested byte to the target address.
- R4: After the data write, status reads of the target continue until at least three reads have been made and the two most recent are equal, or until POLL_MAX reads have been made, whichever comes first.
- R5: If the final status read differs from the requested byte, the block examines the read taken two reads before the last one. If bit 5 of that read is set, the result code is 2 (internal fault); otherwise it is 3 (program did not take).
- R6: `ack` is high for exactly one cycle per accepted request, and `status` is valid in that cycle. The codes are: 0 ok, 1 warning, 2 internal fault, 3 program failure.
- R7: While `fl_valid` is high and `fl_ready` is low, the address, write enable and write data stay unchanged into the next cycle.
- R8: A request is accepted only while the sequencer is idle. A request raised during an operation has no effect on that operation and does not start another one.
- R9: The flash bus is idle out of reset. A transfer begins only in the cycle after an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Start a byte program (accepted when idle) |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to store |
| ack | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with ack |
| fl_valid | output | 1 | Flash transfer pending |
| fl_we | output | 1 | Transfer is a write |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_ready | input | 1 | Flash completes the pending transfer |
| fl_rdata | input | 8 | Flash read data, valid with fl_ready on reads |

## Verification
The bench builds the block with ADDR_W = 12 and POLL_MAX = 12. At that limit, status sequences that never settle run into the read cap within a few dozen cycles, so timeout classification is exercised next to early agreement. The bench sweeps every pairing of 16 old-byte and 16 new-byte patterns. It varies the number of toggling status samples, the final settled value and the bit 5 of the toggling samples, which together reach the skip, warning, internal-fault and program-fault outcomes. A request injected in mid-operation checks that the active program goes on unchanged.

// File: rtl/nor_byte_prog.sv
module nor_byte_prog #(
  parameter int ADDR_W   = 20,
  parameter int POLL_MAX = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              ack,
  output logic [1:0]        status,
  output logic              fl_valid,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic              fl_ready,
  input  logic [7:0]        fl_rdata
);
  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [1:0] ST_OK = 2'd0, ST_WARN = 2'd1, ST_INT = 2'd2, ST_PROG = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PEEK, S_CMD, S_POLL} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [1:0]        step;
  logic              z2o;
  logic [7:0]        hist [4];
  logic [CW-1:0]     cnt;

  wire [CW-1:0] cnt_n = cnt + 1'b1;
  wire [7:0]    prev  = hist[cnt[1:0] - 2'd1];
  wire [7:0]    diag  = hist[cnt[1:0] - 2'd2];
  wire          settle = (cnt_n >= CW'(3)) && (fl_rdata == prev);
  wire          stop   = settle || (cnt_n >= CW'(POLL_MAX));

  assign fl_valid = (st != S_IDLE);
  assign fl_we    = (st == S_CMD);

  always_comb begin
    fl_addr  = addr_q;
    fl_wdata = 8'h00;
    if (st == S_CMD) begin
      case (step)
        2'd0: begin fl_addr = ADDR_W'(12'h555); fl_wdata = 8'hAA; end
        2'd1: begin fl_addr = ADDR_W'(12'h2AA); fl_wdata = 8'h55; end
        2'd2: begin fl_addr = ADDR_W'(12'h555); fl_wdata = 8'hA0; end
        default: begin fl_addr = addr_q; fl_wdata = data_q; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      step   <= '0;
      z2o    <= 1'b0;
      cnt    <= '0;
      ack    <= 1'b0;
      status <= ST_OK;
      for (int i = 0; i < 4; i++) hist[i] <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          addr_q <= req_addr;
          data_q <= req_data;
          st     <= S_PEEK;
        end
        S_PEEK: if (fl_ready) begin
          if (fl_rdata == data_q) begin
            ack    <= 1'b1;
            status <= ST_OK;
            st     <= S_IDLE;
          end else begin
            z2o  <= |(~fl_rdata & data_q);
            step <= 2'd0;
            st   <= S_CMD;
          end
        end
        S_CMD: if (fl_ready) begin
          step <= step + 2'd1;
          if (step == 2'd3) begin
            cnt <= '0;
            st  <= S_POLL;
          end
        end
        S_POLL: if (fl_ready) begin
          hist[cnt[1:0]] <= fl_rdata;
          cnt <= cnt_n;
          if (stop) begin
            ack <= 1'b1;
            st  <= S_IDLE;
            if (fl_rdata == data_q) status <= z2o ? ST_WARN : ST_OK;
            else                    status <= diag[5] ? ST_INT : ST_PROG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_byte_prog_chk.sv
module nor_byte_prog_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ack,
  input logic              fl_valid,
  input logic              fl_we,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata,
  input logic              fl_ready
);
  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r6_ack_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !fl_valid);

  a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_addr) && $stable(fl_we) && $stable(fl_wdata)));

  a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_valid) |-> $past(req));
endmodule

bind nor_byte_prog nor_byte_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .fl_valid(fl_valid),
  .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ready(fl_ready)
);

// File: tb/tb_nor_byte_prog.sv
module tb_nor_byte_prog;
  localparam int AW = 12;
  localparam int LIM = 12;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic ack, fl_valid, fl_we, fl_ready;
  logic [1:0] status;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #5ns clk = ~clk;

  nor_byte_prog #(.ADDR_W(AW), .POLL_MAX(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
    .ack(ack), .status(status), .fl_valid(fl_valid), .fl_we(fl_we), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_ready(fl_ready), .fl_rdata(fl_rdata));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_old = '0, m_fin = '0;
  int m_t = 0;
  logic m_b5 = 1'b0, m_clr = 1'b0;
  int wcnt, rcnt, peeks, hold_viol;
  logic [AW-1:0] wa [8];
  logic [7:0] wd [8];
  logic pend_q;
  logic [AW-1:0] pa_q;
  logic [7:0] pd_q;
  logic pw_q;

  function automatic logic [7:0] stat(int i, logic [7:0] fin, int t, logic b5);
    logic [31:0] iv = i;
    if (i < t) return {~fin[7], iv[0], b5, fin[4:0]};
    return fin;
  endfunction

  assign fl_rdata = (wcnt < 4) ? m_old : stat(rcnt, m_fin, m_t, m_b5);

  always @(posedge clk) begin
    if (!rst_n) begin
      fl_ready <= 1'b0;
    end else begin
      fl_ready <= fl_valid && !fl_ready;
    end
    if (!rst_n || m_clr) begin
      wcnt <= 0; rcnt <= 0; peeks <= 0;
      if (!rst_n) hold_viol <= 0;
    end else if (fl_valid && fl_ready) begin
      if (fl_we) begin
        wa[wcnt & 7] <= fl_addr; wd[wcnt & 7] <= fl_wdata; wcnt <= wcnt + 1;
      end else if (wcnt >= 4) rcnt <= rcnt + 1;
      else peeks <= peeks + 1;
    end
    if (rst_n && pend_q && (!fl_valid || fl_addr != pa_q || fl_wdata != pd_q || fl_we != pw_q))
      hold_viol <= hold_viol + 1;
    pend_q <= rst_n && fl_valid && !fl_ready;
    pa_q <= fl_addr; pd_q <= fl_wdata; pw_q <= fl_we;
  end

  task automatic check(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wait_ack(output bit got);
    int g = 0;
    while (ack !== 1'b1 && g < 400) begin @(negedge clk); g++; end
    got = (ack === 1'b1);
  endtask

  task automatic run(logic [7:0] old, logic [7:0] data, logic [7:0] fin, int t, logic b5,
                     logic [AW-1:0] a);
    int n; int ecode; logic [7:0] last, dg; bit got;
    @(negedge clk);
    m_old = old; m_fin = fin; m_t = t; m_b5 = b5; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0; req = 1'b1; req_addr = a; req_data = data;
    @(negedge clk);
    req = 1'b0;
    wait_ack(got);
    check(got, "R6 ack", got, 1);
    if (old == data) begin
      check(status == 2'd0, "R1 skip status", status, 0);
      check(wcnt == 0, "R1 no writes", wcnt, 0);
      check(peeks == 1, "R1 single peek", peeks, 1);
    end else begin
      n = LIM;
      for (int i = 2; i < LIM; i++)
        if (stat(i, fin, t, b5) == stat(i-1, fin, t, b5)) begin n = i + 1; break; end
      last = stat(n-1, fin, t, b5);
      dg = stat(n-3, fin, t, b5);
      if (last == data) ecode = ((~old & data) != 0) ? 1 : 0;
      else ecode = dg[5] ? 2 : 3;
      if (ecode == 1) check(status == 2'd1, "R2 warn status", status, ecode);
      else if (ecode == 0) check(status == 2'd0, "R6 ok status", status, ecode);
      else check(status == 2'(ecode), "R5 fail class", status, ecode);
      check(wcnt == 4 && wa[0] == 12'h555 && wd[0] == 8'hAA && wa[1] == 12'h2AA &&
            wd[1] == 8'h55 && wa[2] == 12'h555 && wd[2] == 8'hA0 && wa[3] == a &&
            wd[3] == data, "R3 command sequence", wcnt, 4);
      check(rcnt == n, "R4 status read count", rcnt, n);
      check(peeks == 1, "R1 peek before program", peeks, 1);
    end
    @(negedge clk);
    check(ack == 1'b0, "R6 ack one cycle", ack, 0);
  endtask

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    check(fl_valid == 1'b0 && ack == 1'b0, "R9 reset bus idle", {fl_valid, ack}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fl_valid == 1'b0, "R9 idle without req", fl_valid, 0);

    for (int o = 0; o < 16; o++)
      for (int d = 0; d < 16; d++) begin
        logic [7:0] ov, dv, fv;
        ov = {4'(o), 4'(o)} ^ 8'h3C;
        dv = {4'(d), 4'(15 - d)};
        case ((o + d) % 3)
          0: fv = dv;
          1: fv = ov & dv;
          default: fv = dv ^ 8'h01;
        endcase
        run(ov, dv, fv, (o + d) % 5, o[0], AW'(o * 16 + d + 7));
      end
    run(8'h00, 8'h5A, 8'h5A, 100, 1'b1, 12'h0F0);
    run(8'h00, 8'h5A, 8'h5A, 100, 1'b0, 12'h0F1);
    run(8'hFF, 8'h12, 8'h12, LIM - 2, 1'b0, 12'h0F2);

    @(negedge clk);
    m_old = 8'hFF; m_fin = 8'h66; m_t = 3; m_b5 = 1'b0; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0; req = 1'b1; req_addr = 12'h321; req_data = 8'h66;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; req_addr = 12'h123; req_data = 8'h99;
    @(negedge clk);
    req = 1'b0;
    wait_ack(got);
    check(got && status == 2'd0, "R8 busy req ignored status", status, 0);
    check(wa[3] == 12'h321 && wd[3] == 8'h66, "R8 target unchanged", wa[3], 12'h321);
    repeat (10) @(negedge clk);
    check(fl_valid == 1'b0 && peeks == 1, "R8 no second op", peeks, 1);
    check(hold_viol == 0, "R7 pending transfer held", hold_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule